// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the digital front end of a 12-bit converter with a serial control port. A host frames each transfer with an active-low chip select and toggles an I/O clock. In the same frame the host shifts a 4-bit command address in and the block shifts the previous result out. The address picks one of eleven external channels, one of three internal self-test voltages, power-down, or a reserved code. The block drives the multiplexer select and the sample and hold strobes. It requests a conversion from an external converter core and stores the returned value in an output buffer. That value is shifted out during the following frame, so results lag commands by one frame.

The block runs on its own system clock. It synchronises the chip select, I/O clock and serial data inputs and detects their edges. Frames are 12 I/O clocks long. A conversion in progress makes the block busy. A frame that starts while the block is busy is ignored and flagged. After reset the block is in power-down, and any channel or self-test address brings it out.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, pd_o is 1, busy_o, err_o, sample_o, hold_o and conv_req_o are 0, sdo_o is 0 while cs_ni is high, and the output buffer holds zero.
- R2: The address is taken from sdi_i on the first four I/O clock rising edges of a frame, most significant bit first. For addresses 0 to 10, chan_o equals the address after the fourth falling edge.
- R3: For addresses 0 to 13, sample_o rises at the fourth falling edge of the I/O clock. At the twelfth falling edge sample_o falls and hold_o pulses high for one system clock.
- R4: Addresses 0 to 10 give one conv_req_o pulse at the end of the frame. busy_o is then set and stays high until conv_done_i, when conv_data_i is stored in the output buffer.
- R5: In the next frame the buffer is shifted out on sdo_o, most significant bit first. Bit 11 is valid after cs_ni falls, and each further bit is valid after each I/O clock falling edge.
- R6: Address 11 (1011) loads half scale 0x800, address 12 (1100) loads 0x000 and address 13 (1101) loads full scale 0xFFF into the buffer at the end of the frame. These addresses raise neither conv_req_o nor busy_o.
- R7: Address 14 (1110) sets pd_o at the fourth falling edge and gives no sample, hold or conversion. The buffer keeps its previous value.
- R8: Any address from 0 to 13 clears pd_o at the fourth falling edge.
- R9: Address 15 (1111) gives no sample, hold or conversion and leaves pd_o unchanged.
- R10: A frame that starts while busy_o is high raises err_o for that frame. That frame gives no sample, hold or conversion and leaves pd_o unchanged. err_o clears at the next frame that starts while not busy.
- R11: conv_done_i while busy_o is low has no effect on the buffer.
- R12: If cs_ni rises before the twelfth falling edge, the frame is aborted: sample_o falls and no hold or conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial I/O clock |
| cs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial address input |
| sdo_o | output | 1 | Serial result output |
| sample_o | output | 1 | Sampling window to the analog front end |
| hold_o | output | 1 | One-cycle hold strobe |
| chan_o | output | 4 | Multiplexer channel select |
| conv_req_o | output | 1 | Conversion request pulse |
| conv_done_i | input | 1 | Conversion complete from the core |
| conv_data_i | input | 12 | Converted value from the core |
| busy_o | output | 1 | Conversion outstanding |
| pd_o | output | 1 | Power-down state |
| err_o | output | 1 | Current or last frame was ignored because busy |

## Verification
The hardest case to reach is a frame that overlaps an unfinished conversion. To create it, the bench holds back conv_done_i after a channel frame and starts a new frame carrying the power-down address. It then checks that err_o is raised, that neither pd_o nor the strobes move, and that the buffer later shows only the delayed result. An aborted frame and a stray conv_done_i while idle are then applied. The next full frame reads the buffer back to show that neither one changed it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned LAST_CH = 10;
  localparam int unsigned LAST_TST = 13;
  localparam int unsigned PD_ADDR = 14;

  typedef enum logic [1:0] {
    K_ANALOG,
    K_TEST,
    K_PDOWN,
    K_RSVD
  } addr_kind_e;

  function automatic addr_kind_e kind_of(input logic [ADDR_W-1:0] a);
    if (a <= ADDR_W'(LAST_CH))       return K_ANALOG;
    else if (a <= ADDR_W'(LAST_TST)) return K_TEST;
    else if (a == ADDR_W'(PD_ADDR))  return K_PDOWN;
    else                             return K_RSVD;
  endfunction
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame #(
  parameter int unsigned FRAME_LEN = 12,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_stb_o,
  output logic              end_stb_o,
  output logic              active_o,
  output logic              ign_o
);
  localparam int unsigned CW = $clog2(FRAME_LEN + 1);

  logic [CW-1:0] rcnt_q, fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_stb_o <= 1'b0;
      end_stb_o  <= 1'b0;
      active_o   <= 1'b0;
      ign_o      <= 1'b0;
      rcnt_q     <= '0;
      fcnt_q     <= '0;
    end else begin
      addr_stb_o <= 1'b0;
      end_stb_o  <= 1'b0;
      if (cs_fall_i) begin
        active_o <= 1'b1;
        ign_o    <= busy_i;
        rcnt_q   <= '0;
        fcnt_q   <= '0;
      end else if (cs_rise_i) begin
        active_o <= 1'b0;
      end else if (active_o) begin
        if (sck_rise_i && rcnt_q < CW'(ADDR_W)) begin
          addr_o <= {addr_o[ADDR_W-2:0], sdi_i};
          rcnt_q <= rcnt_q + 1'b1;
        end
        if (sck_fall_i) begin
          fcnt_q <= fcnt_q + 1'b1;
          if (fcnt_q == CW'(ADDR_W - 1) && !ign_o) addr_stb_o <= 1'b1;
          if (fcnt_q == CW'(FRAME_LEN - 1)) begin
            active_o <= 1'b0;
            if (!ign_o) end_stb_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_obuf.sv
module adc_seq_obuf #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              start_i,
  input  logic              shift_i,
  input  logic              en_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] buf_q, sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      sh_q  <= '0;
    end else begin
      if (load_i) buf_q <= load_data_i;
      if (start_i)      sh_q <= buf_q;
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo_o = en_i & sh_q[DATA_W-1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned FRAME_LEN = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sample_o,
  output logic              hold_o,
  output logic [ADDR_W-1:0] chan_o,
  output logic              conv_req_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              busy_o,
  output logic              pd_o,
  output logic              err_o
);
  localparam logic [DATA_W-1:0] CODE_MID  = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] CODE_ZERO = '0;
  localparam logic [DATA_W-1:0] CODE_FULL = '1;

  logic [2:0] lvl, rise, fall;
  logic       cs_fall, cs_rise, sck_rise, sck_fall;
  logic [ADDR_W-1:0] addr;
  logic       addr_stb, end_stb, active, ign;
  addr_kind_e kind;
  logic [DATA_W-1:0] test_code, load_data;
  logic       test_load, done_load;
  logic       unused_sync;

  adc_seq_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign cs_fall  = fall[2];
  assign cs_rise  = rise[2];
  assign sck_rise = rise[1];
  assign sck_fall = fall[1];
  assign unused_sync = ^{lvl[2:1], rise[0], fall[0]};

  adc_seq_frame #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W)) u_frame (
    .clk_i, .rst_ni,
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .sdi_i      (lvl[0]),
    .busy_i     (busy_o),
    .addr_o     (addr),
    .addr_stb_o (addr_stb),
    .end_stb_o  (end_stb),
    .active_o   (active),
    .ign_o      (ign)
  );

  assign kind  = kind_of(addr);
  assign err_o = ign;

  always_comb begin
    unique case (addr)
      ADDR_W'(LAST_CH + 1): test_code = CODE_MID;
      ADDR_W'(LAST_CH + 2): test_code = CODE_ZERO;
      default:              test_code = CODE_FULL;
    endcase
  end

  // sample_o high means this frame carried a channel or self-test address
  assign test_load = end_stb & sample_o & (kind == K_TEST);
  assign done_load = busy_o & conv_done_i;
  assign load_data = test_load ? test_code : conv_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o       <= 1'b1;
      busy_o     <= 1'b0;
      sample_o   <= 1'b0;
      hold_o     <= 1'b0;
      conv_req_o <= 1'b0;
      chan_o     <= '0;
    end else begin
      hold_o     <= 1'b0;
      conv_req_o <= 1'b0;
      if (addr_stb) begin
        unique case (kind)
          K_PDOWN:  pd_o <= 1'b1;
          K_ANALOG: begin pd_o <= 1'b0; sample_o <= 1'b1; chan_o <= addr; end
          K_TEST:   begin pd_o <= 1'b0; sample_o <= 1'b1; end
          default:  ;
        endcase
      end
      if (end_stb) begin
        sample_o <= 1'b0;
        if (sample_o) begin
          hold_o <= 1'b1;
          if (kind == K_ANALOG) begin
            conv_req_o <= 1'b1;
            busy_o     <= 1'b1;
          end
        end
      end else if (cs_rise) begin
        sample_o <= 1'b0;
      end
      if (done_load) busy_o <= 1'b0;
    end
  end

  adc_seq_obuf #(.DATA_W(DATA_W)) u_obuf (
    .clk_i, .rst_ni,
    .load_i      (test_load | done_load),
    .load_data_i (load_data),
    .start_i     (cs_fall),
    .shift_i     (sck_fall & active),
    .en_i        (active),
    .sdo_o
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sample_o,
  input logic hold_o,
  input logic conv_req_o,
  input logic conv_done_i,
  input logic busy_o,
  input logic pd_o,
  input logic err_o
);
  a_r3_hold_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> !hold_o);

  a_r3_hold_ends_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (!sample_o && $past(sample_o)));

  a_r4_req_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> busy_o);

  a_r4_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !conv_done_i) |=> busy_o);

  a_r4_req_with_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> hold_o);

  a_r7_pd_no_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> !sample_o);

  a_r10_err_no_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !sample_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (.*);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int H = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sdi_i = 1'b0;
  logic        sdo_o, sample_o, hold_o, conv_req_o, busy_o, pd_o, err_o;
  logic [3:0]  chan_o;
  logic        conv_done_i = 1'b0;
  logic [11:0] conv_data_i = '0;

  int total = 0;
  int bad = 0;
  int hold_cnt = 0;
  int req_cnt = 0;
  logic [11:0] exp_buf = '0;
  logic        pd_m = 1'b1;

  always #2 clk_i = ~clk_i;

  adc_seq_ctrl u_adc_seq_ctrl (.*);

  always @(posedge clk_i) begin
    if (hold_o) hold_cnt <= hold_cnt + 1;
    if (conv_req_o) req_cnt <= req_cnt + 1;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] model(input logic [3:0] a);
    return 12'(int'(a) * 12'h123 + 12'h05A);
  endfunction

  task automatic run_frame(input logic [3:0] a, input int nfall, input logic [11:0] exp_out,
                           input bit ign);
    logic [11:0] got;
    int h0, r0;
    bit conv_ok;
    h0 = hold_cnt;
    r0 = req_cnt;
    conv_ok = !ign && (a <= 4'd13);
    got = '0;
    cs_ni = 1'b0;
    wait_n(H);
    got[11] = sdo_o;
    for (int i = 0; i < nfall; i++) begin
      sdi_i = (i < 4) ? a[3-i] : 1'b0;
      wait_n(2);
      sclk_i = 1'b1;
      wait_n(H);
      sclk_i = 1'b0;
      wait_n(H);
      if (i < 11) got[10-i] = sdo_o;
      if (i == 3) begin
        chk(sample_o == conv_ok, "R3 sample after 4th fall", sample_o, conv_ok);
        if (conv_ok && a <= 4'd10) chk(chan_o == a, "R2 chan_o", chan_o, a);
        chk(err_o == ign, "R10 err_o in frame", err_o, ign);
      end
    end
    cs_ni = 1'b1;
    wait_n(H);
    if (nfall == 12) chk(got == exp_out, "R5 shifted result", got, exp_out);
    chk(sample_o == 1'b0, "R3/R12 sample dropped", sample_o, 0);
    chk(hold_cnt - h0 == ((conv_ok && nfall == 12) ? 1 : 0), "R3 hold pulses",
        hold_cnt - h0, (conv_ok && nfall == 12) ? 1 : 0);
    chk(req_cnt - r0 == ((conv_ok && a <= 4'd10 && nfall == 12) ? 1 : 0), "R4 conv_req pulses",
        req_cnt - r0, (conv_ok && a <= 4'd10 && nfall == 12) ? 1 : 0);
  endtask

  task automatic do_done(input logic [11:0] d);
    wait_n(3);
    conv_data_i = d;
    conv_done_i = 1'b1;
    wait_n(1);
    conv_done_i = 1'b0;
    conv_data_i = '0;
    wait_n(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(5);
    rst_ni = 1'b1;
    wait_n(5);
    // R1 reset state
    chk(pd_o == 1'b1, "R1 pd_o", pd_o, 1);
    chk(busy_o == 1'b0, "R1 busy_o", busy_o, 0);
    chk(sdo_o == 1'b0, "R1 sdo_o", sdo_o, 0);
    chk(err_o == 1'b0, "R1 err_o", err_o, 0);

    // R7 power-down frame while in power-down, R9 reserved keeps pd
    run_frame(4'd14, 12, 12'h000, 1'b0);
    chk(pd_o == 1'b1, "R7 pd_o kept", pd_o, 1);
    run_frame(4'd15, 12, 12'h000, 1'b0);
    chk(pd_o == 1'b1, "R9 pd_o unchanged", pd_o, 1);

    // sweep all addresses
    for (int a = 0; a < 16; a++) begin
      run_frame(4'(a), 12, exp_buf, 1'b0);
      if (a <= 10) begin
        chk(busy_o == 1'b1, "R4 busy after channel frame", busy_o, 1);
        do_done(model(4'(a)));
        exp_buf = model(4'(a));
        chk(busy_o == 1'b0, "R4 busy cleared by done", busy_o, 0);
      end else if (a <= 13) begin
        exp_buf = (a == 11) ? 12'h800 : (a == 12) ? 12'h000 : 12'hFFF;
        chk(busy_o == 1'b0, "R6 no busy on self-test", busy_o, 0);
      end
      if (a == 14) pd_m = 1'b1;
      else if (a <= 13) pd_m = 1'b0;
      chk(pd_o == pd_m, (a == 14) ? "R7 pd set" : (a == 15) ? "R9 pd kept" : "R8 pd cleared",
          pd_o, pd_m);
    end

    // R10 frame while busy
    run_frame(4'd0, 12, exp_buf, 1'b0);
    chk(pd_o == 1'b0, "R8 pd cleared by channel 0", pd_o, 0);
    chk(busy_o == 1'b1, "R10 busy held", busy_o, 1);
    run_frame(4'd14, 12, exp_buf, 1'b1);
    chk(err_o == 1'b1, "R10 err_o after ignored frame", err_o, 1);
    chk(pd_o == 1'b0, "R10 pd unchanged", pd_o, 0);
    do_done(model(4'd0));
    exp_buf = model(4'd0);

    // R11 stray done while idle
    do_done(12'hABC);
    chk(busy_o == 1'b0, "R11 busy stays low", busy_o, 0);

    // R12 aborted frame
    run_frame(4'd3, 6, exp_buf, 1'b0);
    chk(busy_o == 1'b0, "R12 no busy after abort", busy_o, 0);

    // readback confirms R11 and R12 left buffer alone; R10 err cleared
    run_frame(4'd13, 12, exp_buf, 1'b0);
    chk(err_o == 1'b0, "R10 err cleared", err_o, 0);
    run_frame(4'd12, 12, 12'hFFF, 1'b0);
    run_frame(4'd11, 12, 12'h000, 1'b0);
    run_frame(4'd15, 12, 12'h800, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule